// File: doc/BRIEF.md
# Integer Add, Subtract and Compare Unit

This is a purely combinational 64-bit integer execute slice. It takes two 64-bit operands and a 7-bit function code. In the same cycle it returns a 64-bit result, an overflow-trap flag and an illegal-function flag. The B operand has already been chosen upstream, either from a register or from an immediate. The unit sits in the integer pipe after operand selection. Its outputs go to the writeback mux and the trap logic.

Each operation is either word-sized (32-bit) or full width (64-bit). Word-sized results are sign-extended from bit 31. The first operand can be pre-multiplied by 4 or 8 before the add or subtract. There are signed and unsigned compares that return 0 or 1. A lane-parallel unsigned compare returns one bit per byte.

Top module: `int_addcmp_unit`

## Requirements
- R1: Codes 0x00 (add) and 0x09 (subtract) work on the low 32 bits of A and B. Every 32-bit form, the trapping ones included, places bit 31 of its result into bits 63:32.
- R2: Codes 0x20 (add) and 0x29 (subtract) return A+B and A-B modulo 2^64.
- R3: Scaled forms compute (A<<2) or (A<<3) with B added or subtracted. 32-bit: 0x02 (x4 add), 0x12 (x8 add), 0x0b (x4 sub), 0x1b (x8 sub). 64-bit: 0x22, 0x32, 0x2b, 0x3b, in the same order.
- R4: Trapping adds are 0x40 (32-bit) and 0x60 (64-bit). ovf_trap is 1 when the sign bits of A and B match and the result sign differs from A's sign. The result is still driven.
- R5: Trapping subtracts are 0x49 (32-bit) and 0x69 (64-bit). ovf_trap is 1 when the sign bits of A and B differ and the result sign differs from A's sign. The result is still driven.
- R6: ovf_trap is 0 for every code other than 0x40, 0x60, 0x49 and 0x69.
- R7: Compares return 1 or 0 in bit 0, with all other bits zero. The codes are:
  - 0x2d: equal
  - 0x4d: signed less-than
  - 0x6d: signed less-or-equal
  - 0x1d: unsigned less-than
  - 0x3d: unsigned less-or-equal
- R8: Code 0x0f sets result bit i when unsigned byte i of A (bits 8i+7:8i) is greater than or equal to byte i of B. Bits 63:8 are zero.
- R9: Any code not listed above sets illegal_fn to 1 and drives result to 0 and ovf_trap to 0. illegal_fn is 0 for every listed code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (register or immediate) |
| fn_code | input | 7 | Function code |
| result | output | 64 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping form |
| illegal_fn | output | 1 | Function code is not recognised |

## Verification
The unit holds no state, so a fault can only come from a wrong decode or wrong datapath logic. Any such fault shows up on the outputs in the same cycle as the stimulus.

A wrong decode entry usually shows as a zero result with illegal_fn set. It can also show as the wrong operand width, which exposes unextended or truncated upper bits.

Overflow errors only appear near the sign boundaries. For that reason every code is driven with directed operands at the 32-bit and 64-bit extremes, as well as with random operands.

// File: rtl/int_addcmp_pkg.sv
package int_addcmp_pkg;
  localparam int XLEN = 64;
  localparam int HALF = 32;
  localparam int FN_W = 7;

  typedef enum logic [1:0] {SC_1, SC_4, SC_8} scale_e;
  typedef enum logic [1:0] {SEL_SUM, SEL_CMP, SEL_BYTE} sel_e;
  typedef enum logic [2:0] {CMP_EQ, CMP_SLT, CMP_SLE, CMP_ULT, CMP_ULE} cmp_e;

  typedef struct packed {
    logic   legal;
    logic   sub;
    logic   word;
    logic   trap;
    scale_e scale;
    sel_e   sel;
    cmp_e   cmp;
  } op_ctl_t;
endpackage

// File: rtl/int_fn_decode.sv
module int_fn_decode
  import int_addcmp_pkg::*;
#(
  parameter int FW = FN_W
) (
  input  logic [FW-1:0] fn,
  output op_ctl_t       ctl
);
  always_comb begin
    ctl       = '0;
    ctl.legal = 1'b1;
    ctl.scale = SC_1;
    ctl.sel   = SEL_SUM;
    ctl.cmp   = CMP_EQ;
    unique case (fn)
      7'h00: ctl.word = 1'b1;
      7'h20: ;
      7'h02: begin ctl.word = 1'b1; ctl.scale = SC_4; end
      7'h12: begin ctl.word = 1'b1; ctl.scale = SC_8; end
      7'h22: ctl.scale = SC_4;
      7'h32: ctl.scale = SC_8;
      7'h09: begin ctl.word = 1'b1; ctl.sub = 1'b1; end
      7'h29: ctl.sub = 1'b1;
      7'h0b: begin ctl.word = 1'b1; ctl.sub = 1'b1; ctl.scale = SC_4; end
      7'h1b: begin ctl.word = 1'b1; ctl.sub = 1'b1; ctl.scale = SC_8; end
      7'h2b: begin ctl.sub = 1'b1; ctl.scale = SC_4; end
      7'h3b: begin ctl.sub = 1'b1; ctl.scale = SC_8; end
      7'h40: begin ctl.word = 1'b1; ctl.trap = 1'b1; end
      7'h60: ctl.trap = 1'b1;
      7'h49: begin ctl.word = 1'b1; ctl.trap = 1'b1; ctl.sub = 1'b1; end
      7'h69: begin ctl.trap = 1'b1; ctl.sub = 1'b1; end
      7'h2d: begin ctl.sel = SEL_CMP; ctl.cmp = CMP_EQ;  end
      7'h4d: begin ctl.sel = SEL_CMP; ctl.cmp = CMP_SLT; end
      7'h6d: begin ctl.sel = SEL_CMP; ctl.cmp = CMP_SLE; end
      7'h1d: begin ctl.sel = SEL_CMP; ctl.cmp = CMP_ULT; end
      7'h3d: begin ctl.sel = SEL_CMP; ctl.cmp = CMP_ULE; end
      7'h0f: ctl.sel = SEL_BYTE;
      default: ctl.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_addsub.sv
module int_addsub
  import int_addcmp_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int HW = HALF
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_ctl_t      ctl,
  output logic [W-1:0] res,
  output logic         ovf
);
  localparam int EXT = W - HW;

  logic [W-1:0] a_sc;
  logic [W-1:0] sum;
  logic         sa, sb, sr;

  always_comb begin
    unique case (ctl.scale)
      SC_4:    a_sc = a << 2;
      SC_8:    a_sc = a << 3;
      default: a_sc = a;
    endcase
    sum = ctl.sub ? (a_sc - b) : (a_sc + b);
    res = ctl.word ? {{EXT{sum[HW-1]}}, sum[HW-1:0]} : sum;
    sa  = ctl.word ? a[HW-1]   : a[W-1];
    sb  = ctl.word ? b[HW-1]   : b[W-1];
    sr  = ctl.word ? sum[HW-1] : sum[W-1];
    ovf = ctl.trap && ((ctl.sub ? (sa != sb) : (sa == sb)) && (sr != sa));
  end
endmodule

// File: rtl/int_cmp.sv
module int_cmp
  import int_addcmp_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  cmp_e         op,
  output logic         hit
);
  logic eq, slt, ult;

  always_comb begin
    eq  = (a == b);
    slt = ($signed(a) < $signed(b));
    ult = (a < b);
    unique case (op)
      CMP_SLT: hit = slt;
      CMP_SLE: hit = slt | eq;
      CMP_ULT: hit = ult;
      CMP_ULE: hit = ult | eq;
      default: hit = eq;
    endcase
  end
endmodule

// File: rtl/int_bytecmp.sv
module int_bytecmp #(
  parameter int W     = 64,
  parameter int LANE  = 8,
  localparam int NL   = W / LANE
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  output logic [NL-1:0] mask
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign mask[i] = (a[i*LANE +: LANE] >= b[i*LANE +: LANE]);
  end
endmodule

// File: rtl/int_addcmp_unit.sv
module int_addcmp_unit
  import int_addcmp_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int HW = HALF,
  parameter int FW = FN_W,
  localparam int NL = W / 8
) (
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [FW-1:0] fn_code,
  output logic [W-1:0]  result,
  output logic          ovf_trap,
  output logic          illegal_fn
);
  op_ctl_t       ctl;
  logic [W-1:0]  sum_res;
  logic          sum_ovf;
  logic          cmp_hit;
  logic [NL-1:0] lane_mask;

  int_fn_decode #(.FW(FW)) u_dec (.fn(fn_code), .ctl(ctl));

  int_addsub #(.W(W), .HW(HW)) u_as (
    .a(op_a), .b(op_b), .ctl(ctl), .res(sum_res), .ovf(sum_ovf)
  );

  int_cmp #(.W(W)) u_cmp (.a(op_a), .b(op_b), .op(ctl.cmp), .hit(cmp_hit));

  int_bytecmp #(.W(W), .LANE(8)) u_bc (.a(op_a), .b(op_b), .mask(lane_mask));

  always_comb begin
    illegal_fn = ~ctl.legal;
    ovf_trap   = ctl.legal & sum_ovf;
    result     = '0;
    if (ctl.legal) begin
      unique case (ctl.sel)
        SEL_CMP:  result = {{(W-1){1'b0}}, cmp_hit};
        SEL_BYTE: result = {{(W-NL){1'b0}}, lane_mask};
        default:  result = sum_res;
      endcase
    end
  end

  always_comb begin
    // R1
    word_sext_chk: assert (!(ctl.legal && ctl.sel == SEL_SUM && ctl.word)
                           || result[W-1:HW] == {(W-HW){result[HW-1]}});
    // R6
    no_overflow_chk: assert (!ovf_trap || ctl.trap);
    // R7
    cmp_bool_chk: assert (!(ctl.legal && ctl.sel == SEL_CMP) || result[W-1:1] == '0);
    // R8
    lane_upper_chk: assert (!(ctl.legal && ctl.sel == SEL_BYTE) || result[W-1:NL] == '0);
    // R9
    illegal_quiet_chk: assert (!illegal_fn || (result == '0 && !ovf_trap));
  end
endmodule

// File: tb/int_addcmp_unit_bench.sv
module int_addcmp_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [63:0] op_a, op_b, result;
  logic [6:0]  fn_code;
  logic        ovf_trap, illegal_fn;
  int          n_run, n_fail;
  bit          done;

  int_addcmp_unit u_int_addcmp_unit (
    .op_a(op_a), .op_b(op_b), .fn_code(fn_code),
    .result(result), .ovf_trap(ovf_trap), .illegal_fn(illegal_fn)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  localparam int NCODES = 22;
  logic [6:0] codes [NCODES] = '{7'h00, 7'h20, 7'h02, 7'h12, 7'h22, 7'h32,
    7'h09, 7'h29, 7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h40, 7'h60, 7'h49, 7'h69,
    7'h2d, 7'h4d, 7'h6d, 7'h1d, 7'h3d, 7'h0f};

  localparam int NDIR = 12;
  logic [63:0] dir_a [NDIR] = '{64'h0, 64'h1, 64'h7fff_ffff, 64'h8000_0000,
    64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, 64'hffff_ffff_ffff_ffff,
    64'h0000_0000_ffff_ffff, 64'h1234_5678_9abc_def0, 64'h7fff_ffff, 64'h8000_0000_0000_0000,
    64'h00ff_7f80_0102_fe01};
  logic [63:0] dir_b [NDIR] = '{64'h0, 64'hffff_ffff_ffff_ffff, 64'h1, 64'h8000_0000,
    64'h1, 64'h8000_0000_0000_0000, 64'h1, 64'h0000_0000_8000_0000,
    64'h1234_5678_9abc_def0, 64'hffff_ffff_8000_0000, 64'h1,
    64'hff00_807f_0102_ff00};

  function automatic string tag_of(input logic [6:0] c);
    case (c)
      7'h00, 7'h09:                      return "R1";
      7'h20, 7'h29:                      return "R2";
      7'h40, 7'h60:                      return "R4";
      7'h49, 7'h69:                      return "R5";
      7'h2d, 7'h4d, 7'h6d, 7'h1d, 7'h3d: return "R7";
      7'h0f:                             return "R8";
      default:                           return "R3";
    endcase
  endfunction

  function automatic bit is_listed(input logic [6:0] c);
    foreach (codes[i]) if (codes[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [63:0] sx32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic [6:0] c,
                       output logic [63:0] r, output logic o);
    longint la, lb, t;
    logic signed [64:0] w;
    int mul;
    bit word, sub, trap;
    r = 0; o = 0;
    la = longint'($signed(sx32(a[31:0])));
    lb = longint'($signed(sx32(b[31:0])));
    mul = (c inside {7'h02, 7'h22, 7'h0b, 7'h2b}) ? 4 :
          (c inside {7'h12, 7'h32, 7'h1b, 7'h3b}) ? 8 : 1;
    word = c inside {7'h00, 7'h02, 7'h12, 7'h09, 7'h0b, 7'h1b, 7'h40, 7'h49};
    sub  = c inside {7'h09, 7'h29, 7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h49, 7'h69};
    trap = c inside {7'h40, 7'h60, 7'h49, 7'h69};
    case (c)
      7'h2d: r = {63'b0, a == b};
      7'h4d: r = {63'b0, $signed(a) <  $signed(b)};
      7'h6d: r = {63'b0, $signed(a) <= $signed(b)};
      7'h1d: r = {63'b0, a <  b};
      7'h3d: r = {63'b0, a <= b};
      7'h0f: for (int k = 0; k < 8; k++) r[k] = (a[8*k +: 8] >= b[8*k +: 8]);
      default: begin
        if (word) begin
          t = sub ? (la * mul - lb) : (la * mul + lb);
          r = sx32(t[31:0]);
          o = trap && (t != longint'($signed(r)));
        end else begin
          r = sub ? (a * mul - b) : (a * mul + b);
          w = sub ? ($signed({a[63], a}) - $signed({b[63], b}))
                  : ($signed({a[63], a}) + $signed({b[63], b}));
          o = trap && (w[64] != w[63]);
        end
      end
    endcase
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp,
                       input string what);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s fn=%h a=%h b=%h: actual %h expected %h",
               tag, what, fn_code, op_a, op_b, got, exp);
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [6:0] c);
    logic [63:0] er;
    logic eo;
    @(posedge clk);
    #2;
    op_a = a; op_b = b; fn_code = c;
    @(negedge clk);
    model(a, b, c, er, eo);
    check(tag_of(c), result, er, "result");
    // R6 for non-trapping codes, R4/R5 for trapping ones
    check((c inside {7'h40, 7'h60, 7'h49, 7'h69}) ? tag_of(c) : "R6",
          {63'b0, ovf_trap}, {63'b0, eo}, "ovf");
    check("R9", {63'b0, illegal_fn}, 64'h0, "illegal");
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    op_a = 0; op_b = 0; fn_code = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state: zero operands, add code
    check("R1", result, 64'h0, "idle result");
    check("R6", {63'b0, ovf_trap}, 64'h0, "idle ovf");
    for (int v = 0; v < NDIR; v++)
      for (int k = 0; k < NCODES; k++) apply(dir_a[v], dir_b[v], codes[k]);
    for (int v = 0; v < 150; v++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (v % 3 == 0) ? ra ^ (64'h1 << (v % 64)) : {$urandom, $urandom};
      for (int k = 0; k < NCODES; k++) apply(ra, rb, codes[k]);
    end
    // R9: every unlisted code is flagged and silent
    for (int c = 0; c < 128; c++) begin
      if (!is_listed(7'(c))) begin
        @(posedge clk);
        #2;
        op_a = 64'h8000_0000_7fff_ffff; op_b = 64'h8000_0000_7fff_ffff; fn_code = 7'(c);
        @(negedge clk);
        check("R9", {63'b0, illegal_fn}, 64'h1, "illegal");
        check("R9", result, 64'h0, "illegal result");
        check("R9", {63'b0, ovf_trap}, 64'h0, "illegal ovf");
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule